// File: doc/BRIEF.md
# Multi-Channel Reload Timer Unit

This block holds three down-counting timer channels and one wide free-running up-counter behind a small register bus. The first two channels are 16 bits wide and the third is 32 bits wide. Each channel is enabled and set up by its own control register. On underflow, a channel either reloads from its load register or wraps to all ones, and it raises a level interrupt. That interrupt stays high until software writes to the channel's clear register.

The up-counter is 40 bits wide and steps on the fast tick enable. It is turned on and off through bit 8 of its high register, and it never drives an interrupt. Two tick-enable inputs stand in for the slow (about 508 kHz) and fast (about 983 kHz) timebases.

Typical use: write 0x48 to a channel's control register (set up but stopped), write N-1 to its load register, then write 0xC8. The channel then interrupts once every N slow ticks.

Top module: `reload_timer_unit`

## Requirements
- R1: After reset, all counts, load registers and control registers read 0, every interrupt line is low, and the up-counter is stopped at 0.
- R2: A write to a channel's load register (offset 0x0) while its control bit 7 is 0 also sets the count, and the value register (offset 0x4) then reads the written value.
- R3: A channel counts only while control bit 7 is 1. It decrements once per slowTick when control bit 3 is 1, and once per fastTick when bit 3 is 0. While bit 7 is 0 the count holds.
- R4: With control bit 6 set, a tick at count 0 reloads the count from the load register, so a load value of N-1 gives an interrupt every N ticks.
- R5: With control bit 6 clear, a tick at count 0 wraps the count to all ones of the channel width.
- R6: A tick at count 0 drives that channel's interrupt line high, and the line stays high until a clear write.
- R7: A write of any value to a channel's clear register (offset 0xC) drops its interrupt. If the same cycle also underflows, the interrupt stays high.
- R8: Channels 0 and 1 keep only the low 16 bits of a load write, and channel 2 keeps all 32 bits. Counts and load values read back zero-extended.
- R9: The control register (offset 0x8) reads back the low 8 bits of the last written value, with bits 31:8 as 0.
- R10: A load write while a channel is enabled changes only the load register. The running count continues and the new value is used at the next reload.
- R11: Writing the up-counter high register (0x34) with bit 8 set makes the counter count up once per fastTick. Writing it with bit 8 clear stops the counter and clears it to 0. Register 0x30 reads count bits 31:0, and 0x34 reads {bit 8 = enable, bits 7:0 = count bits 39:32}. The up-counter never changes an interrupt line.
- R12: Channel c sits at base c*0x10 for c = 0..2, and the up-counter sits at 0x30 and 0x34. Reads of write-only or unmapped addresses, and any read with busRd low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as busRd |
| slowTick | input | 1 | Slow timebase enable |
| fastTick | input | 1 | Fast timebase enable |
| chanIrq | output | 3 | Level interrupt per down-counting channel |

## Verification
The bench measures the reload period, which catches the common off-by-one: a design that reloaded on reaching zero, not on the tick after it, would interrupt every N-1 ticks. It drives an underflow and a clear write in the same cycle. A design that let the clear win there would silently lose an event.

It also checks that a load write to a running channel leaves the count alone. It checks wrap-to-all-ones in one-shot mode, the truncation of load values in the 16-bit channels, and the tick-select bit. A design that ignored the tick-select bit would count on the wrong timebase.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int NUM_CH    = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int CTRL_W    = 8;
  localparam int FREE_W    = 40;
  localparam int FREE_HI_W = FREE_W - DATA_W;
  localparam int NARROW_W  = 16;

  localparam int EN_BIT      = 7;
  localparam int PERIOD_BIT  = 6;
  localparam int SLOWSEL_BIT = 3;
  localparam int FREE_EN_BIT = 8;

  localparam logic [1:0] OFF_LOAD  = 2'd0;
  localparam logic [1:0] OFF_VALUE = 2'd1;
  localparam logic [1:0] OFF_CTRL  = 2'd2;
  localparam logic [1:0] OFF_CLEAR = 2'd3;
  localparam logic [1:0] FREE_SEL  = 2'd3;

  function automatic int chanWidth(input int c);
    return (c == NUM_CH - 1) ? DATA_W : NARROW_W;
  endfunction

  typedef struct packed {
    logic [NUM_CH-1:0] loadWr;
    logic [NUM_CH-1:0] ctrlWr;
    logic [NUM_CH-1:0] clearWr;
    logic              freeHiWr;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import rtu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadWr,
  input  logic              ctrlWr,
  input  logic              clearWr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              slowTick,
  input  logic              fastTick,
  output logic [W-1:0]      countQ,
  output logic [W-1:0]      loadQ,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irq
);
  logic enabled, tick, atZero, underflow;

  assign enabled   = ctrlQ[EN_BIT];
  assign tick      = enabled & (ctrlQ[SLOWSEL_BIT] ? slowTick : fastTick);
  assign atZero    = (countQ == '0);
  assign underflow = tick & atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      loadQ  <= '0;
      ctrlQ  <= '0;
      irq    <= 1'b0;
    end else begin
      if (loadWr) loadQ <= wdata[W-1:0];
      if (ctrlWr) ctrlQ <= wdata[CTRL_W-1:0];
      if (tick) begin
        if (atZero) countQ <= ctrlQ[PERIOD_BIT] ? loadQ : '1;
        else        countQ <= countQ - 1'b1;
      end else if (loadWr && !enabled) begin
        countQ <= wdata[W-1:0];
      end
      if (underflow)    irq <= 1'b1;
      else if (clearWr) irq <= 1'b0;
    end
  end

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !loadWr) |=> $stable(countQ));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !atZero) |=> (countQ == $past(countQ) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && ctrlQ[PERIOD_BIT]) |=> (countQ == $past(loadQ)));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !ctrlQ[PERIOD_BIT]) |=> (countQ == {W{1'b1}}));
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !underflow) |=> !irq);
  assert_running_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadWr && enabled && !tick) |=> $stable(countQ));
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import rtu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobes,
  input  logic                           slowTick,
  input  logic                           fastTick,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanValue,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanLoad,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  chanCtrl,
  output logic [NUM_CH-1:0]              chanIrq,
  output logic [FREE_W-1:0]              freeCnt,
  output logic                           freeEn
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int CW = chanWidth(c);
    logic [CW-1:0] countQ, loadQ;
    timer_channel #(.W(CW)) i_channel (
      .clk      (clk),
      .rstN     (rstN),
      .loadWr   (strobes.loadWr[c]),
      .ctrlWr   (strobes.ctrlWr[c]),
      .clearWr  (strobes.clearWr[c]),
      .wdata    (strobes.wdata),
      .slowTick (slowTick),
      .fastTick (fastTick),
      .countQ   (countQ),
      .loadQ    (loadQ),
      .ctrlQ    (chanCtrl[c]),
      .irq      (chanIrq[c])
    );
    assign chanValue[c] = DATA_W'(countQ);
    assign chanLoad[c]  = DATA_W'(loadQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt <= '0;
      freeEn  <= 1'b0;
    end else if (strobes.freeHiWr) begin
      freeEn <= strobes.wdata[FREE_EN_BIT];
      if (!strobes.wdata[FREE_EN_BIT]) freeCnt <= '0;
    end else if (freeEn && fastTick) begin
      freeCnt <= freeCnt + 1'b1;
    end
  end

  assert_free_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (freeEn && fastTick && !strobes.freeHiWr) |=> (freeCnt == $past(freeCnt) + 1'b1));
  assert_free_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.freeHiWr && !strobes.wdata[FREE_EN_BIT]) |=> (freeCnt == '0 && !freeEn));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import rtu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWr,
  input  logic                           busRd,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  output strobe_t                        strobes,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanValue,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanLoad,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]  chanCtrl,
  input  logic [FREE_W-1:0]              freeCnt,
  input  logic                           freeEn
);
  logic       regionOk;
  logic [1:0] sel, off;

  assign regionOk = (busAddr[ADDR_W-1:6] == '0);
  assign sel      = busAddr[5:4];
  assign off      = busAddr[3:2];

  always_comb begin
    strobes       = '0;
    strobes.wdata = busWdata;
    if (busWr && regionOk) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel == 2'(c)) begin
          strobes.loadWr[c]  = (off == OFF_LOAD);
          strobes.ctrlWr[c]  = (off == OFF_CTRL);
          strobes.clearWr[c] = (off == OFF_CLEAR);
        end
      end
      if (sel == FREE_SEL && off == 2'd1) strobes.freeHiWr = 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd && regionOk) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel == 2'(c)) begin
          case (off)
            OFF_LOAD:  busRdata = chanLoad[c];
            OFF_VALUE: busRdata = chanValue[c];
            OFF_CTRL:  busRdata = DATA_W'(chanCtrl[c]);
            default:   busRdata = '0;
          endcase
        end
      end
      if (sel == FREE_SEL) begin
        if (off == 2'd0)      busRdata = freeCnt[DATA_W-1:0];
        else if (off == 2'd1) busRdata = DATA_W'({freeEn, freeCnt[FREE_W-1:DATA_W]});
      end
    end
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadWr, strobes.ctrlWr, strobes.clearWr, strobes.freeHiWr}));
  assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0));
endmodule

// File: rtl/reload_timer_unit.sv
module reload_timer_unit
  import rtu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              slowTick,
  input  logic              fastTick,
  output logic [NUM_CH-1:0] chanIrq
);
  strobe_t                       strobes;
  logic [NUM_CH-1:0][DATA_W-1:0] chanValue, chanLoad;
  logic [NUM_CH-1:0][CTRL_W-1:0] chanCtrl;
  logic [FREE_W-1:0]             freeCnt;
  logic                          freeEn;

  timer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobes(strobes),
    .chanValue(chanValue), .chanLoad(chanLoad), .chanCtrl(chanCtrl),
    .freeCnt(freeCnt), .freeEn(freeEn)
  );

  timer_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slowTick(slowTick),
    .fastTick(fastTick), .chanValue(chanValue), .chanLoad(chanLoad),
    .chanCtrl(chanCtrl), .chanIrq(chanIrq), .freeCnt(freeCnt), .freeEn(freeEn)
  );

  assert_free_no_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearWr == '0 && $stable(chanCtrl) && !slowTick && !fastTick) |=> $stable(chanIrq));
endmodule

// File: tb/test_reload_timer_unit.sv
module test_reload_timer_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        slowTick = 1'b0, fastTick = 1'b0;
  logic [2:0]  chanIrq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer_unit i_reload_timer_unit (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .slowTick(slowTick),
    .fastTick(fastTick), .chanIrq(chanIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit s, input bit f);
    @(negedge clk);
    busWr = wr; busAddr = a; busWdata = d; slowTick = s; fastTick = f;
    @(negedge clk);
    busWr = 1'b0; slowTick = 1'b0; fastTick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic fast(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1 ch0 value", 8'h04, 0);
    expectReg("R1 ch2 load", 8'h20, 0);
    expectReg("R1 ch1 ctrl", 8'h18, 0);
    expectReg("R1 free high", 8'h34, 0);
    check("R1 irq", chanIrq, 3'b000);
  endtask

  task automatic testPeriodic();
    wr(8'h08, 32'h48);
    wr(8'h00, 32'd9);
    expectReg("R2 load while off", 8'h04, 9);
    slow(2);
    expectReg("R3 hold while off", 8'h04, 9);
    wr(8'h08, 32'hC8);
    slow(9);
    expectReg("R3 count to zero", 8'h04, 0);
    check("R6 no irq before underflow", chanIrq, 3'b000);
    slow(1);
    check("R6 irq on underflow", chanIrq, 3'b001);
    expectReg("R4 reload", 8'h04, 9);
    slow(3);
    check("R6 irq held", chanIrq, 3'b001);
    wr(8'h0C, 32'h0);
    check("R7 clear", chanIrq, 3'b000);
    slow(6);
    check("R4 no early irq", chanIrq, 3'b000);
    slow(1);
    check("R4 period of 10 ticks", chanIrq, 3'b001);
    wr(8'h0C, 32'h5A);
    slow(9);
    check("R7 cleared before collision", chanIrq, 3'b000);
    cycle(1'b1, 8'h0C, 32'h0, 1'b1, 1'b0);
    check("R7 underflow wins over clear", chanIrq, 3'b001);
    wr(8'h0C, 32'h0);
    check("R7 clear after collision", chanIrq, 3'b000);
  endtask

  task automatic testRunningLoad();
    wr(8'h00, 32'd3);
    expectReg("R10 count kept", 8'h04, 9);
    expectReg("R10 load updated", 8'h00, 3);
    slow(9);
    expectReg("R10 old count reaches zero", 8'h04, 0);
    slow(1);
    expectReg("R10 new load used", 8'h04, 3);
    wr(8'h08, 32'h48);
    slow(2);
    expectReg("R3 stopped", 8'h04, 3);
    wr(8'h0C, 32'h0);
  endtask

  task automatic testTickSelectAndWrap();
    wr(8'h18, 32'h40);
    wr(8'h10, 32'd5);
    wr(8'h18, 32'hC0);
    slow(2);
    expectReg("R3 fast channel ignores slow tick", 8'h14, 5);
    fast(1);
    expectReg("R3 fast tick steps", 8'h14, 4);
    wr(8'h18, 32'h80);
    fast(4);
    expectReg("R5 at zero", 8'h14, 0);
    fast(1);
    expectReg("R5 wrap 16 bit", 8'h14, 32'hFFFF);
    check("R6 ch1 irq", chanIrq, 3'b010);
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);
    check("R7 ch1 clear", chanIrq, 3'b000);
  endtask

  task automatic testWidths();
    wr(8'h00, 32'hABCD1234);
    expectReg("R8 narrow value", 8'h04, 32'h1234);
    expectReg("R8 narrow load", 8'h00, 32'h1234);
    wr(8'h20, 32'h12345678);
    expectReg("R8 wide value", 8'h24, 32'h12345678);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h88);
    slow(1);
    expectReg("R5 wrap 32 bit", 8'h24, 32'hFFFFFFFF);
    check("R6 ch2 irq", chanIrq, 3'b100);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h18, 32'hFFFFFF37);
    expectReg("R9 ctrl readback", 8'h18, 32'h37);
  endtask

  task automatic testFree();
    logic [2:0] irqBefore;
    irqBefore = chanIrq;
    wr(8'h34, 32'h100);
    fast(5);
    slow(2);
    expectReg("R11 low count", 8'h30, 5);
    expectReg("R11 high word", 8'h34, 32'h100);
    check("R11 no interrupt", chanIrq, irqBefore);
    wr(8'h34, 32'h0);
    expectReg("R11 stop clears", 8'h30, 0);
    expectReg("R12 clear reads zero", 8'h0C, 0);
    expectReg("R12 unmapped", 8'h38, 0);
    expectReg("R12 upper region", 8'h44, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPeriodic();
    testRunningLoad();
    testTickSelectAndWrap();
    testWidths();
    testFree();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule